// File: doc/BRIEF.md
# Transmit FIFO Empty Interrupt Generator

This block watches how full a transmit FIFO is and raises a sticky "FIFO has room" status bit once the occupancy falls to a programmed threshold. Software chooses between two thresholds: the bit fires when the FIFO is at least half empty, or only when it has drained completely. The comparison runs only while the data path is in processor-driven (non-DMA) mode. When DMA owns the data movement, the status stays quiet.

The status bit drives a single interrupt line through a global unmask bit. The mask gates only the line. The status bit keeps tracking the FIFO whatever the mask is set to, so software can poll it with the line masked. The interrupt line is registered, so it follows the status by one cycle. Software clears the status with a write-one-to-clear strobe. If the threshold is still met, the bit sets again on the next cycle.

Top module: `txf_empty_irq`

## Requirements
- R1: After reset, the status output `room_stat` and the line `irq` are both 0.
- R2: With `full_sel`=0 and `dma_on`=0, `room_stat` becomes 1 one clock after a cycle in which 2*`occupancy` <= `depth`. It does not set in cycles where 2*`occupancy` > `depth`.
- R3: With `full_sel`=1 and `dma_on`=0, `room_stat` sets one clock after a cycle in which `occupancy`=0, and never from any non-zero occupancy.
- R4: Once set, `room_stat` stays 1 while `stat_clr` is 0, even after the FIFO refills above the threshold.
- R5: A cycle with `stat_clr`=1 makes `room_stat` 0 at the next clock. If the threshold still holds in the cycle after that, the bit is 1 again one clock later.
- R6: While `dma_on`=1, `room_stat` never goes from 0 to 1, whatever the occupancy and threshold setting.
- R7: `irq` equals the AND of `room_stat` and `glb_unmask` as they stood in the previous cycle, so the line lags the status by one clock.
- R8: With `glb_unmask`=0, `irq` stays 0, but `room_stat` still sets and clears as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occupancy | input | OCC_W | Number of entries currently held in the FIFO |
| depth | input | OCC_W | Total FIFO capacity in entries |
| full_sel | input | 1 | Threshold select: 0 = half empty, 1 = completely empty |
| dma_on | input | 1 | 1 = DMA mode, which suppresses status setting |
| glb_unmask | input | 1 | 1 = interrupt line enabled, 0 = masked |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| room_stat | output | 1 | Sticky FIFO-empty status bit |
| irq | output | 1 | Registered, masked interrupt line |

## Verification
The hardest situation to reach is a clear strobe that lands while the threshold still holds. The bit must drop for exactly one cycle and then come back. To reach it, the stimulus holds a qualifying occupancy and pulses `stat_clr` for one cycle. It then samples the status after each of the next two edges. A second hard case is a change in the boundary occupancy: odd depths must land on the correct side of half. The vector table therefore pairs each depth with the occupancy just inside the threshold and the one just outside it.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Configuration bits that steer the threshold logic
  typedef struct packed {
    logic full_sel;   // 1: fire only when completely empty
    logic dma_on;     // 1: DMA mode, status not set
  } txf_cfg_t;

  // Threshold arithmetic: half-empty means occ*2 <= depth
  function automatic logic thresh_met(input int unsigned occ,
                                      input int unsigned depth,
                                      input logic        full_sel);
    if (full_sel) return (occ == 0);
    return ((occ << 1) <= depth);
  endfunction

endpackage

// File: rtl/txf_level_cmp.sv
module txf_level_cmp
  import txf_pkg::*;
#(
  parameter int OCC_W = 8
) (
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] depth_i,
  input  txf_cfg_t         cfg_i,
  output logic             hit_o
);

  logic thr_met;

  assign thr_met = thresh_met(32'(occ_i), 32'(depth_i), cfg_i.full_sel);
  assign hit_o   = thr_met && !cfg_i.dma_on;

endmodule

// File: rtl/txf_stat_reg.sv
module txf_stat_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_o <= 1'b0;
    else if (clr_i) stat_o <= 1'b0;
    else if (set_i) stat_o <= 1'b1;
  end

  // R4: sticky while no clear
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o && !clr_i |=> stat_o);

  // R5: a clear strobe drops the bit at the next edge
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !stat_o);

  // R5: with the condition held after a clear, the bit returns
  a_r5_reset_again: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> stat_o);

endmodule

// File: rtl/txf_irq_gate.sv
module txf_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_i,
  input  logic unmask_i,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= stat_i & unmask_i;
  end

  // R8: masked line stays low next cycle
  a_r8_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
    !unmask_i |=> !irq_o);

  // R7: unmasked status reaches the line one cycle later
  a_r7_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
    stat_i && unmask_i |=> irq_o);

endmodule

// File: rtl/txf_empty_irq.sv
module txf_empty_irq
  import txf_pkg::*;
#(
  parameter int OCC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] depth,
  input  logic             full_sel,
  input  logic             dma_on,
  input  logic             glb_unmask,
  input  logic             stat_clr,
  output logic             room_stat,
  output logic             irq
);

  txf_cfg_t cfg;
  logic     thr_hit;   // threshold event, brought out for checks

  assign cfg.full_sel = full_sel;
  assign cfg.dma_on   = dma_on;

  txf_level_cmp #(.OCC_W(OCC_W)) u_cmp (
    .occ_i   (occupancy),
    .depth_i (depth),
    .cfg_i   (cfg),
    .hit_o   (thr_hit)
  );

  txf_stat_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (thr_hit),
    .clr_i  (stat_clr),
    .stat_o (room_stat)
  );

  txf_irq_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_i   (room_stat),
    .unmask_i (glb_unmask),
    .irq_o    (irq)
  );

  // R6: DMA mode never sets a cleared status
  a_r6_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on && !room_stat |=> !room_stat);

  // R3: full-empty mode ignores non-zero occupancy
  a_r3_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    full_sel && (occupancy != '0) && !room_stat |=> !room_stat);

  // R2: half mode with more than half full does not set
  a_r2_over_half: assert property (@(posedge clk) disable iff (!rst_n)
    !full_sel && ({1'b0, occupancy} + {1'b0, occupancy} > {1'b0, depth})
      && !room_stat |=> !room_stat);

endmodule

// File: tb/txf_empty_irq_test.sv
module txf_empty_irq_test;

  localparam int OCC_W = 8;
  localparam int NV    = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [OCC_W-1:0] occupancy = '0;
  logic [OCC_W-1:0] depth = '0;
  logic             full_sel = 1'b0;
  logic             dma_on = 1'b0;
  logic             glb_unmask = 1'b0;
  logic             stat_clr = 1'b0;
  logic             room_stat;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  txf_empty_irq #(.OCC_W(OCC_W)) uut (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .depth(depth),
    .full_sel(full_sel), .dma_on(dma_on), .glb_unmask(glb_unmask),
    .stat_clr(stat_clr), .room_stat(room_stat), .irq(irq)
  );

  // vector: depth, occupancy, full_sel, dma_on
  typedef struct packed {
    logic [7:0] dep;
    logic [7:0] occ;
    logic       fs;
    logic       dm;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd16,  8'd8,   1'b0, 1'b0},
    '{8'd16,  8'd9,   1'b0, 1'b0},
    '{8'd16,  8'd0,   1'b1, 1'b0},
    '{8'd16,  8'd1,   1'b1, 1'b0},
    '{8'd16,  8'd16,  1'b0, 1'b0},
    '{8'd16,  8'd0,   1'b0, 1'b1},
    '{8'd15,  8'd7,   1'b0, 1'b0},
    '{8'd15,  8'd8,   1'b0, 1'b0},
    '{8'd200, 8'd100, 1'b0, 1'b0},
    '{8'd200, 8'd0,   1'b1, 1'b1}
  };

  // free space at least equal to occupancy means half empty
  function automatic bit model_hit(int dep, int occ, bit fs, bit dm);
    if (dm) return 1'b0;
    if (fs) return occ == 0;
    return (dep - occ) >= occ;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 stat", room_stat, 1'b0);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    depth = 8'd16;
    occupancy = 8'd16;
    tick();

    // Table walk: R2 R3 R6 R7
    glb_unmask = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bit e;
      e = model_hit(int'(VECS[i].dep), int'(VECS[i].occ), VECS[i].fs, VECS[i].dm);
      depth = VECS[i].dep;
      occupancy = VECS[i].occ;
      full_sel = VECS[i].fs;
      dma_on = VECS[i].dm;
      stat_clr = 1'b1;
      tick();
      stat_clr = 1'b0;
      tick();
      check(VECS[i].dm ? "R6 dma stat" : (VECS[i].fs ? "R3 full stat" : "R2 half stat"),
            room_stat, e);
      tick();
      check("R7 irq follows", irq, e);
    end

    // R4: sticky after refill
    dma_on = 1'b0; full_sel = 1'b0; depth = 8'd16; occupancy = 8'd2;
    tick();
    occupancy = 8'd16;
    tick();
    tick();
    check("R4 sticky", room_stat, 1'b1);

    // R5: clear while threshold still holds -> drop then return
    occupancy = 8'd3;
    stat_clr = 1'b1;
    tick();
    stat_clr = 1'b0;
    check("R5 cleared", room_stat, 1'b0);
    tick();
    check("R5 sets again", room_stat, 1'b1);

    // R8: masked line stays low, status still updates
    glb_unmask = 1'b0;
    stat_clr = 1'b1;
    tick();
    stat_clr = 1'b0;
    tick();
    check("R8 stat updates", room_stat, 1'b1);
    tick();
    check("R8 line masked", irq, 1'b0);
    // R7: line rises exactly one clock after unmask
    glb_unmask = 1'b1;
    check("R7 before edge", irq, 1'b0);
    tick();
    check("R7 one-cycle lag", irq, 1'b1);

    finish_run();
  end

endmodule